// File: doc/BRIEF.md
# Fixed-Point Alpha Mixer

This block mixes two RGB pixels, a live video pixel and an on-screen-display pixel, into one output pixel under an 8-bit opacity value. Each colour component is weighted separately. The video sample is scaled by the opacity and the overlay sample by its complement. The weighted sum is then normalised back to the 8-bit range. Only integer arithmetic is used.

The complement weight is made with a bitwise inversion of the opacity rather than a subtractor. The divide by 255 becomes a multiply by a fixed reciprocal of 392 on a 10^5 scale. A constant divide by 10^5 with round-half-up follows. The three stages are fully pipelined, so a new pixel can enter on every clock. A valid flag travels beside the data, and there is no backpressure.

Top module: `alpha_mixer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_pixel` are 0.
- R2: `out_valid` equals `in_valid` as sampled three rising edges earlier. The result for a pixel accepted at edge k is on the outputs after edge k+2.
- R3: For each component, with v the video sample, o the overlay sample and a the opacity, the output is min(255, floor((v·a·392 + o·(a XOR 255)·392 + 50000) / 100000)).
- R4: With a = 255, every output component is within ±1 of the video component.
- R5: With a = 0, every output component is within ±1 of the overlay component.
- R6: Pixels are packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each component is mixed independently of the other two.
- R7: When `out_valid` is 0, `out_pixel` keeps its previous value. Cycles with `in_valid` low do not disturb the pipeline contents.
- R8: Back-to-back valid pixels are accepted on every clock. Each one produces its own result in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_video | input | 24 | Video pixel, R/G/B packed |
| in_osd | input | 24 | Overlay pixel, R/G/B packed |
| in_alpha | input | 8 | Opacity of the video pixel (255 = all video) |
| out_valid | output | 1 | Output pixel qualifier |
| out_pixel | output | 24 | Mixed pixel, R/G/B packed |

## Verification
The checker watches four things on every cycle: the three-cycle valid delay, quiet outputs during reset, the hold of the output pixel in bubble cycles, and the ±1 tolerance at both opacity extremes. The exact rounded value at intermediate opacities, the byte placement of the components and in-order streaming of long back-to-back bursts are shown only by the bench's directed scenarios. The bench compares those against a model computed from the requirement formula.

// File: rtl/alpha_mixer_pkg.sv
package alpha_mixer_pkg;
   localparam int unsigned DEF_DATA_W  = 8;
   localparam int unsigned DEF_ALPHA_W = 8;
   localparam int unsigned DEF_NCOMP   = 3;
   localparam int unsigned DEF_RECIP   = 392;
   localparam int unsigned DEF_SCALE   = 100000;
   localparam int unsigned DEF_ACC_W   = 32;
   localparam int unsigned PIPE_DEPTH  = 3;

   // bits needed to hold value v
   function automatic int unsigned bits_for(input longint unsigned v);
      int unsigned n;
      n = 0;
      while (v != 0) begin
         v = v >> 1;
         n++;
      end
      return (n == 0) ? 1 : n;
   endfunction
endpackage

// File: rtl/alpha_mixer_weight.sv
module alpha_mixer_weight #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ALPHA_W = 8,
   parameter bit          USE_XOR = 1'b1,
   localparam int unsigned PROD_W = DATA_W + ALPHA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [DATA_W-1:0]  vid,
   input  logic [DATA_W-1:0]  osd,
   input  logic [ALPHA_W-1:0] alpha,
   output logic [PROD_W-1:0]  prod_vid,
   output logic [PROD_W-1:0]  prod_osd
);
   localparam logic [ALPHA_W-1:0] FULL = {ALPHA_W{1'b1}};

   logic [ALPHA_W-1:0] cmpl;

   generate
      if (USE_XOR) begin : g_xor
         assign cmpl = alpha ^ FULL;
      end else begin : g_sub
         assign cmpl = FULL - alpha;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_vid <= '0;
         prod_osd <= '0;
      end else if (en) begin
         prod_vid <= PROD_W'(vid) * PROD_W'(alpha);
         prod_osd <= PROD_W'(osd) * PROD_W'(cmpl);
      end
   end
endmodule

// File: rtl/alpha_mixer_scale.sv
module alpha_mixer_scale #(
   parameter int unsigned PROD_W = 16,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned RECIP  = 392,
   parameter int unsigned SCALE  = 100000,
   parameter bit          ROUND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PROD_W-1:0] prod_vid,
   input  logic [PROD_W-1:0] prod_osd,
   output logic [ACC_W-1:0]  acc
);
   localparam int unsigned BIAS = ROUND ? (SCALE / 2) : 0;

   logic [ACC_W-1:0] pair_sum;
   logic [ACC_W-1:0] weighted;

   // shared reciprocal: v*a*R + o*c*R == (v*a + o*c)*R
   assign pair_sum = ACC_W'(prod_vid) + ACC_W'(prod_osd);
   assign weighted = pair_sum * ACC_W'(RECIP) + ACC_W'(BIAS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= weighted;
   end
endmodule

// File: rtl/alpha_mixer_norm.sv
module alpha_mixer_norm #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SCALE  = 100000,
   parameter bit          SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ACC_W-1:0]  acc,
   output logic [DATA_W-1:0] sample
);
   localparam logic [ACC_W-1:0] TOP = ACC_W'((1 << DATA_W) - 1);

   logic [ACC_W-1:0]  quo;
   logic [DATA_W-1:0] clipped;

   assign quo = acc / ACC_W'(SCALE);

   generate
      if (SAT) begin : g_sat
         assign clipped = (quo > TOP) ? TOP[DATA_W-1:0] : quo[DATA_W-1:0];
      end else begin : g_wrap
         assign clipped = quo[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sample <= '0;
      else if (en) sample <= clipped;
   end
endmodule

// File: rtl/alpha_mixer.sv
module alpha_mixer
   import alpha_mixer_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned ALPHA_W = DEF_ALPHA_W,
   parameter int unsigned NCOMP   = DEF_NCOMP,
   parameter int unsigned RECIP   = DEF_RECIP,
   parameter int unsigned SCALE   = DEF_SCALE,
   parameter int unsigned ACC_W   = DEF_ACC_W,
   parameter bit          USE_XOR = 1'b1,
   parameter bit          ROUND   = 1'b1,
   parameter bit          SAT     = 1'b1,
   localparam int unsigned PIX_W  = DATA_W * NCOMP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PIX_W-1:0]   in_video,
   input  logic [PIX_W-1:0]   in_osd,
   input  logic [ALPHA_W-1:0] in_alpha,
   output logic               out_valid,
   output logic [PIX_W-1:0]   out_pixel
);
   localparam int unsigned PROD_W = DATA_W + ALPHA_W;
   localparam longint unsigned WMAX  = (64'd1 << ALPHA_W) - 1;
   localparam longint unsigned SMAX  = (64'd1 << DATA_W) - 1;
   localparam longint unsigned PEAK  = SMAX * WMAX * RECIP + SCALE;
   localparam int unsigned NEED_W    = bits_for(PEAK);

   generate
      if (DATA_W < 1 || ALPHA_W < 1 || NCOMP < 1) begin : g_bad_dim
         $error("alpha_mixer: widths and component count must be positive");
      end
      if (ACC_W < NEED_W) begin : g_bad_acc
         $error("alpha_mixer: ACC_W too narrow for the weighted sum");
      end
      if (RECIP == 0 || SCALE == 0) begin : g_bad_const
         $error("alpha_mixer: reciprocal and scale must be non-zero");
      end
   endgenerate

   logic vld_s1, vld_s2, vld_s3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_s1 <= 1'b0;
         vld_s2 <= 1'b0;
         vld_s3 <= 1'b0;
      end else begin
         vld_s1 <= in_valid;
         vld_s2 <= vld_s1;
         vld_s3 <= vld_s2;
      end
   end

   assign out_valid = vld_s3;

   generate
      for (genvar c = 0; c < NCOMP; c++) begin : g_comp
         logic [PROD_W-1:0] pv, po;
         logic [ACC_W-1:0]  acc;
         logic [DATA_W-1:0] res;

         alpha_mixer_weight #(
            .DATA_W (DATA_W),
            .ALPHA_W(ALPHA_W),
            .USE_XOR(USE_XOR)
         ) u_weight (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (in_valid),
            .vid     (in_video[c*DATA_W +: DATA_W]),
            .osd     (in_osd[c*DATA_W +: DATA_W]),
            .alpha   (in_alpha),
            .prod_vid(pv),
            .prod_osd(po)
         );

         alpha_mixer_scale #(
            .PROD_W(PROD_W),
            .ACC_W (ACC_W),
            .RECIP (RECIP),
            .SCALE (SCALE),
            .ROUND (ROUND)
         ) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (vld_s1),
            .prod_vid(pv),
            .prod_osd(po),
            .acc     (acc)
         );

         alpha_mixer_norm #(
            .ACC_W (ACC_W),
            .DATA_W(DATA_W),
            .SCALE (SCALE),
            .SAT   (SAT)
         ) u_norm (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (vld_s2),
            .acc   (acc),
            .sample(res)
         );

         assign out_pixel[c*DATA_W +: DATA_W] = res;
      end
   endgenerate
endmodule

// File: rtl/alpha_mixer_chk.sv
module alpha_mixer_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ALPHA_W = 8,
   parameter int unsigned NCOMP   = 3,
   localparam int unsigned PIX_W  = DATA_W * NCOMP
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [PIX_W-1:0]   in_video,
   input logic [PIX_W-1:0]   in_osd,
   input logic [ALPHA_W-1:0] in_alpha,
   input logic               out_valid,
   input logic [PIX_W-1:0]   out_pixel
);
   localparam logic [ALPHA_W-1:0] AFULL = {ALPHA_W{1'b1}};

   // cycles since reset release, saturating at pipeline depth
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   function automatic bit near(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      return ((a >= b) ? (a - b) : (b - a)) <= DATA_W'(1);
   endfunction

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_pixel == '0)); // R1

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !out_valid) |-> $stable(out_pixel)); // R7

   generate
      for (genvar c = 0; c < NCOMP; c++) begin : g_ext
         AST_ALPHA_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && $past(in_valid && in_alpha == AFULL, 3))
            |-> near(out_pixel[c*DATA_W +: DATA_W], $past(in_video[c*DATA_W +: DATA_W], 3))); // R4

         AST_ALPHA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && $past(in_valid && in_alpha == '0, 3))
            |-> near(out_pixel[c*DATA_W +: DATA_W], $past(in_osd[c*DATA_W +: DATA_W], 3))); // R5
      end
   endgenerate
endmodule

bind alpha_mixer alpha_mixer_chk #(
   .DATA_W (DATA_W),
   .ALPHA_W(ALPHA_W),
   .NCOMP  (NCOMP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_video (in_video),
   .in_osd   (in_osd),
   .in_alpha (in_alpha),
   .out_valid(out_valid),
   .out_pixel(out_pixel)
);

// File: tb/alpha_mixer_tb.sv
module alpha_mixer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_video = '0;
   logic [23:0] in_osd = '0;
   logic [7:0]  in_alpha = '0;
   logic        out_valid;
   logic [23:0] out_pixel;

   int checks = 0;
   int fails  = 0;

   // model of the three pipeline slots: [0] newest
   logic        pv  [3];
   logic [23:0] pexp[3];
   logic [23:0] pvid[3];
   logic [23:0] posd[3];
   logic [7:0]  pa  [3];
   logic [23:0] last_pix;

   always #2 clk = ~clk;

   alpha_mixer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_video(in_video),
      .in_osd(in_osd), .in_alpha(in_alpha), .out_valid(out_valid), .out_pixel(out_pixel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input logic [7:0] act, input logic [7:0] ref_v);
      int d;
      d = int'(act) - int'(ref_v);
      checks++;
      if (d > 1 || d < -1) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h+-1", req, act, ref_v);
      end
   endtask

   // R3 formula, per component
   function automatic logic [7:0] mix(input logic [7:0] v, input logic [7:0] o, input logic [7:0] a);
      longint t;
      t = (longint'(v) * a * 392 + longint'(o) * (255 - a) * 392 + 50000) / 100000;
      if (t > 255) t = 255;
      return t[7:0];
   endfunction

   function automatic logic [23:0] mix_px(input logic [23:0] v, input logic [23:0] o, input logic [7:0] a);
      return {mix(v[23:16], o[23:16], a), mix(v[15:8], o[15:8], a), mix(v[7:0], o[7:0], a)};
   endfunction

   task automatic clear_model();
      for (int i = 0; i < 3; i++) begin
         pv[i] = 1'b0; pexp[i] = '0; pvid[i] = '0; posd[i] = '0; pa[i] = '0;
      end
      last_pix = '0;
   endtask

   // one clock: check the result due now, then drive the next input
   task automatic step(input logic v, input logic [23:0] vid, input logic [23:0] osd, input logic [7:0] a);
      @(negedge clk);
      chk("R2 out_valid", 32'(out_valid), 32'(pv[2]));
      if (pv[2]) begin
         chk("R3/R8 out_pixel", 32'(out_pixel), 32'(pexp[2]));
         if (pa[2] == 8'hFF)
            for (int c = 0; c < 3; c++) chk_near("R4 alpha=255", out_pixel[c*8 +: 8], pvid[2][c*8 +: 8]);
         if (pa[2] == 8'h00)
            for (int c = 0; c < 3; c++) chk_near("R5 alpha=0", out_pixel[c*8 +: 8], posd[2][c*8 +: 8]);
         last_pix = pexp[2];
      end else begin
         chk("R7 hold when idle", 32'(out_pixel), 32'(last_pix));
      end
      for (int i = 2; i > 0; i--) begin
         pv[i] = pv[i-1]; pexp[i] = pexp[i-1]; pvid[i] = pvid[i-1];
         posd[i] = posd[i-1]; pa[i] = pa[i-1];
      end
      pv[0] = v; pexp[0] = mix_px(vid, osd, a); pvid[0] = vid; posd[0] = osd; pa[0] = a;
      in_valid = v; in_video = vid; in_osd = osd; in_alpha = a;
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step(1'b0, 24'h5A5A5A, 24'hA5A5A5, 8'h33);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b1; in_video = 24'hFFFFFF; in_osd = 24'hFFFFFF; in_alpha = 8'h80;
      @(negedge clk);
      @(negedge clk);
      chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
      chk("R1 out_pixel in reset", 32'(out_pixel), 32'd0);
      in_valid = 1'b0;
      clear_model();
      rst_n = 1'b1;
   endtask

   task automatic t_extremes();
      step(1'b1, 24'hFF8001, 24'h10F0C3, 8'hFF); // R4
      step(1'b1, 24'h00FF7F, 24'hFFFFFF, 8'hFF); // R4
      step(1'b1, 24'h123456, 24'hFEDCBA, 8'h00); // R5
      step(1'b1, 24'hFFFFFF, 24'h00807F, 8'h00); // R5
      flush();
   endtask

   task automatic t_mid();
      step(1'b1, 24'hC8C8C8, 24'h646464, 8'h80); // R3: 150 each
      step(1'b1, 24'hFFFFFF, 24'hFFFFFF, 8'h7F); // R3 full scale
      step(1'b1, 24'h000000, 24'h000000, 8'h55);
      step(1'b1, 24'h0A1432, 24'hF0E6DC, 8'h01);
      step(1'b1, 24'h0A1432, 24'hF0E6DC, 8'hFE);
      flush();
   endtask

   task automatic t_channels();
      step(1'b1, 24'hFF0000, 24'h0000FF, 8'h80);
      repeat (2) step(1'b0, 24'h0, 24'h0, 8'h0);
      @(negedge clk);
      // R6: red from video only, blue from overlay only, green zero
      chk("R6 red byte",   32'(out_pixel[23:16]), 32'd128);
      chk("R6 green byte", 32'(out_pixel[15:8]),  32'd0);
      chk("R6 blue byte",  32'(out_pixel[7:0]),   32'd127);
      chk("R6 valid", 32'(out_valid), 32'd1);
      for (int i = 2; i > 0; i--) begin
         pv[i] = pv[i-1]; pexp[i] = pexp[i-1]; pvid[i] = pvid[i-1];
         posd[i] = posd[i-1]; pa[i] = pa[i-1];
      end
      pv[0] = 1'b0;
      last_pix = 24'h80007F;
      flush();
   endtask

   task automatic t_bubbles();
      step(1'b1, 24'h203040, 24'hD0C0B0, 8'h40);
      step(1'b0, 24'hFFFFFF, 24'hFFFFFF, 8'hFF); // R7 idle inputs ignored
      step(1'b0, 24'h000000, 24'h000000, 8'h00);
      step(1'b1, 24'h99AA11, 24'h1122EE, 8'hC0);
      step(1'b0, 24'h777777, 24'h888888, 8'h10);
      step(1'b1, 24'h010203, 24'hFDFEFF, 8'h20);
      flush();
   endtask

   task automatic t_stream();
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      for (int i = 0; i < 40; i++) begin // R8 back-to-back
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(1'b1, lf[23:0], {lf[7:0], lf[31:16]}, lf[31:24] ^ 8'(i));
      end
      flush();
   endtask

   initial begin
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_extremes();
      t_mid();
      t_channels();
      t_bubbles();
      t_stream();
      t_reset();
      flush();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule